// File: doc/BRIEF.md
# Switch-Driven Display Update Controller

This block is a hard-wired controller for a small front panel. It watches a bank of eight DIP switches, two pushbuttons and one mode toggle. It keeps two 8-bit held values, one for a two-digit hexadecimal seven-segment display and one for an eight-LED bar graph. Each pushbutton selects the display that captures the current switch byte. The mode toggle selects whether the byte is stored as it is or in complemented form.

The two displays complement in different ways. The bar graph stores the bitwise inverse of the switch byte. The seven-segment display stores the two's-complement negative of the switch byte.

Each button first passes through a synchronizer and then a debouncer. A load happens once on each settled press, never again while the button stays down, and never on a short glitch. Segment encoding and digit multiplexing sit downstream of this block.

Top module: `disp_upd_ctl`

## Requirements
- R1: While reset is asserted, and at the first sample after reset, both `seg_val` and `bar_val` read 0x00.
- R2: A settled press of `btn_seg` with `mode_cmpl`=0 loads `seg_val` with `dip_sw` unchanged.
- R3: A settled press of `btn_bar` with `mode_cmpl`=0 loads `bar_val` with `dip_sw` unchanged.
- R4: A press of `btn_bar` with `mode_cmpl`=1 loads `bar_val` with the bitwise inverse of `dip_sw`.
- R5: A press of `btn_seg` with `mode_cmpl`=1 loads `seg_val` with (256 − `dip_sw`) mod 256. For example, 0x01 gives 0xFF, 0x80 gives 0x80 and 0x00 gives 0x00.
- R6: A press of one button leaves the other display's held value unchanged.
- R7: Each press loads exactly once. Changing `dip_sw` or `mode_cmpl` while a button is held, or while no button is pressed, does not alter either held value.
- R8: A button level change passes through two synchronizer flops. It must then stay unchanged for DEBOUNCE_CYC clocks. The load lands on the (DEBOUNCE_CYC+2)-th rising edge after the input changes, which is the 6th edge with the default of 4.
- R9: A button pulse shorter than DEBOUNCE_CYC clocks at the synchronizer output causes no load.
- R10: When both buttons rise in the same cycle, both displays load on the same edge, and each applies its own transform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dip_sw | input | 8 | DIP switch byte |
| btn_seg | input | 1 | Pushbutton that loads the seven-segment value (1 = pressed) |
| btn_bar | input | 1 | Pushbutton that loads the bar-graph value (1 = pressed) |
| mode_cmpl | input | 1 | 0 = store unchanged, 1 = store complemented |
| seg_val | output | 8 | Held seven-segment byte, shown as two hex digits |
| bar_val | output | 8 | Held bar-graph byte, 1 = LED lit |

## Verification
A button change reaches a display only on the sixth rising edge after it is applied, because it passes two synchronizer flops, a four-cycle settle count and the holding register. The bench therefore holds the switch byte and mode steady around every press. It reads the displays only after both the press and the release have settled. One directed case samples one edge before the load and one edge after it to pin the exact latency. Glitch and held-button cases then read both outputs many cycles later, to show that nothing moved.

// File: rtl/disp_ctl_pkg.sv
package disp_ctl_pkg;

  typedef enum logic {
    XF_INVERT = 1'b0,
    XF_NEGATE = 1'b1
  } xform_e;

  // Value a display stores for a given switch byte, mode and display kind.
  function automatic logic [7:0] disp_xform(input logic [7:0] val,
                                            input logic       cmpl,
                                            input xform_e     kind);
    logic [7:0] r;
    if (!cmpl)                 r = val;
    else if (kind == XF_INVERT) r = ~val;
    else                        r = 8'(~val + 8'd1);
    return r;
  endfunction

endpackage

// File: rtl/btn_cond.sv
module btn_cond #(
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_in,
  output logic press_o
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s_sync;
  logic                   stable_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   settle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_in};
  end
  assign s_sync = sync_q[SYNC_STAGES-1];

  // Level must differ from the accepted level for DEBOUNCE_CYC cycles.
  assign settle  = (s_sync != stable_q) && (cnt_q == CNT_LAST);
  assign press_o = settle && s_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b0;
      cnt_q    <= '0;
    end else if (s_sync == stable_q) begin
      cnt_q <= '0;
    end else if (settle) begin
      stable_q <= s_sync;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: a press yields a single-cycle event
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o);

  // R9: an event needs the synchronized level high on the previous cycle too
  a_r9_settled_level: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |-> $past(s_sync));

endmodule

// File: rtl/held_disp.sv
module held_disp
  import disp_ctl_pkg::*;
#(
  parameter int     DATA_W = 8,
  parameter xform_e KIND   = XF_INVERT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              cmpl_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] val_o
);
  logic [DATA_W-1:0] next_val;

  assign next_val = disp_xform(sw_i, cmpl_i, KIND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_o <= '0;
    else if (load_i) val_o <= next_val;
  end

  // R7: without a load the held value never moves
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(val_o));

  // R2/R3: normal mode stores the switch byte unchanged
  a_r2_r3_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !cmpl_i) |=> (val_o == $past(sw_i)));

  generate
    if (KIND == XF_INVERT) begin : g_inv
      // R4: inverse plus original is all ones
      a_r4_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && cmpl_i) |=> ((val_o ^ $past(sw_i)) == {DATA_W{1'b1}}));
    end else begin : g_neg
      // R5: negative plus original wraps to zero
      a_r5_negate: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && cmpl_i) |=> (DATA_W'(val_o + $past(sw_i)) == '0));
    end
  endgenerate

endmodule

// File: rtl/disp_upd_ctl.sv
module disp_upd_ctl
  import disp_ctl_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dip_sw,
  input  logic              btn_seg,
  input  logic              btn_bar,
  input  logic              mode_cmpl,
  output logic [DATA_W-1:0] seg_val,
  output logic [DATA_W-1:0] bar_val
);
  logic seg_press;
  logic bar_press;

  btn_cond #(.SYNC_STAGES(SYNC_STAGES), .DEBOUNCE_CYC(DEBOUNCE_CYC)) u_seg_btn (
    .clk(clk), .rst_n(rst_n), .btn_in(btn_seg), .press_o(seg_press));

  btn_cond #(.SYNC_STAGES(SYNC_STAGES), .DEBOUNCE_CYC(DEBOUNCE_CYC)) u_bar_btn (
    .clk(clk), .rst_n(rst_n), .btn_in(btn_bar), .press_o(bar_press));

  held_disp #(.DATA_W(DATA_W), .KIND(XF_NEGATE)) u_seg_hold (
    .clk(clk), .rst_n(rst_n), .load_i(seg_press), .cmpl_i(mode_cmpl),
    .sw_i(dip_sw), .val_o(seg_val));

  held_disp #(.DATA_W(DATA_W), .KIND(XF_INVERT)) u_bar_hold (
    .clk(clk), .rst_n(rst_n), .load_i(bar_press), .cmpl_i(mode_cmpl),
    .sw_i(dip_sw), .val_o(bar_val));

  // R6: a seven-segment press leaves the bar graph alone, and vice versa
  a_r6_seg_only: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_press && !bar_press) |=> $stable(bar_val));
  a_r6_bar_only: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_press && !seg_press) |=> $stable(seg_val));

  // R1: held values are zero while reset is applied
  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_zero: assert (seg_val == '0 && bar_val == '0);
  end

endmodule

// File: tb/disp_upd_ctl_bench.sv
module disp_upd_ctl_bench;
  localparam int DEB = 4;
  localparam int SETTLE = DEB + 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dip_sw = 8'h00;
  logic       btn_seg = 1'b0, btn_bar = 1'b0, mode_cmpl = 1'b0;
  logic [7:0] seg_val, bar_val;
  logic [7:0] exp_seg = 8'h00, exp_bar = 8'h00;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  disp_upd_ctl #(.DEBOUNCE_CYC(DEB)) u_disp_upd_ctl (
    .clk(clk), .rst_n(rst_n), .dip_sw(dip_sw), .btn_seg(btn_seg),
    .btn_bar(btn_bar), .mode_cmpl(mode_cmpl), .seg_val(seg_val), .bar_val(bar_val));

  function automatic logic [7:0] want_seg(input logic [7:0] v, input logic c);
    return c ? 8'((9'd256 - {1'b0, v}) & 9'hFF) : v;
  endfunction
  function automatic logic [7:0] want_bar(input logic [7:0] v, input logic c);
    return c ? (v ^ 8'hFF) : v;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Press and release with switches held steady, then check both displays.
  task automatic press(input logic s, input logic b, input logic [7:0] v,
                       input logic c, input string req);
    @(negedge clk);
    dip_sw = v; mode_cmpl = c;
    btn_seg = s; btn_bar = b;
    cyc(SETTLE);
    btn_seg = 1'b0; btn_bar = 1'b0;
    cyc(SETTLE);
    if (s) exp_seg = want_seg(v, c);
    if (b) exp_bar = want_bar(v, c);
    chk({req, " seg"}, seg_val, exp_seg);
    chk({req, " bar"}, bar_val, exp_bar);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7043));
    cyc(3);
    chk("R1 in reset seg", seg_val, 8'h00);
    chk("R1 in reset bar", bar_val, 8'h00);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 after reset seg", seg_val, 8'h00);
    chk("R1 after reset bar", bar_val, 8'h00);

    press(1, 0, 8'h5A, 0, "R2 plain seg");
    press(0, 1, 8'hC3, 0, "R3 plain bar");
    press(0, 1, 8'h0F, 1, "R4 invert bar");
    press(1, 0, 8'h01, 1, "R5 negate 01");
    press(1, 0, 8'h80, 1, "R5 negate 80");
    press(1, 0, 8'h00, 1, "R5 negate 00");
    press(0, 1, 8'h00, 1, "R4 invert 00");
    press(1, 0, 8'h7E, 0, "R6 seg only");
    press(0, 1, 8'h24, 1, "R6 bar only");
    press(1, 1, 8'h37, 1, "R10 both cmpl");
    press(1, 1, 8'hA5, 0, "R10 both plain");

    // R8: load lands on edge DEB+2 after the input change
    @(negedge clk);
    dip_sw = 8'h99; mode_cmpl = 1'b0; btn_seg = 1'b1;
    repeat (DEB + 1) @(posedge clk);
    #1 chk("R8 before load edge", seg_val, exp_seg);
    @(posedge clk);
    #1 exp_seg = 8'h99;
    chk("R8 at load edge", seg_val, exp_seg);
    // R7: hold the button, change switches and mode; nothing reloads
    @(negedge clk);
    dip_sw = 8'h11; mode_cmpl = 1'b1;
    cyc(SETTLE * 2);
    chk("R7 held seg", seg_val, exp_seg);
    btn_seg = 1'b0;
    cyc(SETTLE);
    chk("R7 after release seg", seg_val, exp_seg);
    dip_sw = 8'hEE; mode_cmpl = 1'b0;
    cyc(SETTLE);
    chk("R7 idle seg", seg_val, exp_seg);
    chk("R7 idle bar", bar_val, exp_bar);

    // R9: short glitch pulses do not load
    dip_sw = 8'h42;
    btn_bar = 1'b1; cyc(DEB - 2); btn_bar = 1'b0;
    btn_seg = 1'b1; cyc(1); btn_seg = 1'b0;
    cyc(SETTLE);
    chk("R9 glitch bar", bar_val, exp_bar);
    chk("R9 glitch seg", seg_val, exp_seg);

    for (int i = 0; i < 40; i++) begin
      logic [1:0] which;
      which = 2'($urandom_range(1, 3));
      press(which[0], which[1], 8'($urandom), 1'($urandom), "R2-R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule